// File: doc/BRIEF.md
# PCIe Legacy Interrupt Aggregator

This block collects the four legacy virtual interrupt wires of a PCIe root port, A through D, and presents them to the processor as one interrupt line. The link layer gives it decoded message events. An assert event carries a 2-bit pin index and raises that pin's internal level. A deassert event carries a pin index and lowers that pin's level. Each pin behaves as an emulated level-sensitive wire. Its status bit is set while the level is high. Once the level is high, the status bit can be cleared only after the level has dropped.

Software reaches the block through a plain 32-bit register port with two registers. One register holds the per-pin unmask bits. The other holds the per-pin status bits, which are cleared by writing 1. A handler reads the status register, services each set pin from the lowest to the highest, and then clears each serviced bit. The combined interrupt line is registered. It is high when any pin has both its status bit and its unmask bit set. Masking a pin hides it from the line, but its status bit is kept.

Top module: `intx_aggregator`

## Requirements
- R1: After a synchronous reset, all unmask bits, status bits and pin levels are 0, `irq_o` is 0, and `rd_data` is 0.
- R2: The unmask register is at byte offset 0x180 and the status register is at 0x184. Pin n (n=0 for A up to n=3 for D) sits at bit 24+n of both registers. A read strobe loads `rd_data` at the next clock edge with the register contents as they were before that edge. `rd_data` holds its value while no read is strobed.
- R3: An assert event for pin n sets that pin's level and status bit at the clock edge that accepts the event. A repeated assert for a pin that is already high changes nothing.
- R4: While pin n's level is high, writing 1 to its status bit leaves the bit set.
- R5: After a deassert event, the status bit stays set until software writes 1 to it. Writing 0 to a status bit leaves it unchanged.
- R6: When a deassert event and a status write-1 for the same pin arrive in the same cycle, the status bit ends up clear.
- R7: A write to the unmask register loads bits 27:24 of the write data as the new unmask bits. This write does not change any status bit.
- R8: `irq_o` is a register equal to the OR over all pins of (status AND unmask), updated at the same edge as the bits it depends on. A masked pin keeps its status bit and raises `irq_o` once it is unmasked.
- R9: Register bits outside 27:24 read as 0 and ignore writes. Writes to any offset other than the two registers change nothing.
- R10: When an assert event and a deassert event name the same pin in the same cycle, the deassert wins and the pin's level ends up low. When the two events name different pins in the same cycle, both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| asrt_vld | input | 1 | Assert message event strobe |
| asrt_pin | input | 2 | Pin index of the assert event |
| dsrt_vld | input | 1 | Deassert message event strobe |
| dsrt_pin | input | 2 | Pin index of the deassert event |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| rd_data | output | 32 | Registered read data |
| irq_o | output | 1 | Combined interrupt request, registered |

## Verification
The per-pin assertions assume that each message strobe stays high for exactly one cycle per message. They also assume that a pin index is meaningful only while its strobe is high. The bench drives every event and register access as a single-cycle pulse set away from the clock edge, and it parks the pin index at 0 between events. The bench uses same-cycle collisions of a deassert with a clear, and of an assert with a deassert, only in the two scenarios that target them. Every other scenario lets the events settle before it touches the registers.

// File: rtl/intx_pkg.sv
package intx_pkg;
  localparam int unsigned INTX_PINS = 4;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_ENABLE = 2'd1,
    SEL_STATUS = 2'd2
  } intx_sel_e;
endpackage

// File: rtl/intx_pin_cell.sv
module intx_pin_cell #(
  parameter int PIN_IDX_W = 2,
  parameter int PIN_ID    = 0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 asrt_vld,
  input  logic [PIN_IDX_W-1:0] asrt_pin,
  input  logic                 dsrt_vld,
  input  logic [PIN_IDX_W-1:0] dsrt_pin,
  input  logic                 clr,
  output logic                 level_o,
  output logic                 status_o,
  output logic                 status_nxt_o
);
  logic hit_a, hit_d;
  logic level_q, level_nxt;
  logic status_q, status_nxt;

  assign hit_a = asrt_vld && (asrt_pin == PIN_IDX_W'(PIN_ID));
  assign hit_d = dsrt_vld && (dsrt_pin == PIN_IDX_W'(PIN_ID));

  // Deassert dominates a same-cycle assert on this pin.
  always_comb begin
    if (hit_d)      level_nxt = 1'b0;
    else if (hit_a) level_nxt = 1'b1;
    else            level_nxt = level_q;
  end

  // A held level re-sets the bit, so a clear only sticks once the level is low.
  assign status_nxt = level_nxt | (status_q & ~clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q  <= 1'b0;
      status_q <= 1'b0;
    end else begin
      level_q  <= level_nxt;
      status_q <= status_nxt;
    end
  end

  assign level_o      = level_q;
  assign status_o     = status_q;
  assign status_nxt_o = status_nxt;

  a_r3_assert_sets: assert property (@(posedge clk) disable iff (rst)
    (hit_a && !hit_d) |=> (level_q && status_q));
  a_r4_held_level_keeps: assert property (@(posedge clk) disable iff (rst)
    (level_q && !hit_d) |=> status_q);
  a_r5_sticky_status: assert property (@(posedge clk) disable iff (rst)
    (status_q && !clr) |=> status_q);
  a_r6_deassert_clear: assert property (@(posedge clk) disable iff (rst)
    (hit_d && clr) |=> !status_q);
  a_r10_deassert_wins: assert property (@(posedge clk) disable iff (rst)
    (hit_a && hit_d) |=> !level_q);
endmodule

// File: rtl/intx_regs.sv
module intx_regs
  import intx_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int NUM_PINS = 4,
  parameter int PIN_LSB  = 24,
  parameter int EN_ADDR  = 'h180,
  parameter int ST_ADDR  = 'h184
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  input  logic [NUM_PINS-1:0] status_q,
  output logic [NUM_PINS-1:0] en_q,
  output logic [NUM_PINS-1:0] en_nxt,
  output logic [NUM_PINS-1:0] w1c,
  output logic [DATA_W-1:0]   rd_data
);
  intx_sel_e           sel;
  logic [NUM_PINS-1:0] wfield;
  logic [DATA_W-1:0]   rd_word;
  logic [DATA_W-1:0]   rd_q;
  logic                wdata_unused;

  assign wfield       = reg_wdata[PIN_LSB +: NUM_PINS];
  assign wdata_unused = ^reg_wdata;

  always_comb begin
    if (reg_addr == ADDR_W'(EN_ADDR))      sel = SEL_ENABLE;
    else if (reg_addr == ADDR_W'(ST_ADDR)) sel = SEL_STATUS;
    else                                   sel = SEL_NONE;
  end

  assign en_nxt = (reg_wr && sel == SEL_ENABLE) ? wfield : en_q;
  assign w1c    = (reg_wr && sel == SEL_STATUS) ? wfield : '0;

  always_comb begin
    rd_word = '0;
    case (sel)
      SEL_ENABLE: rd_word[PIN_LSB +: NUM_PINS] = en_q;
      SEL_STATUS: rd_word[PIN_LSB +: NUM_PINS] = status_q;
      default:    rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
      rd_q <= '0;
    end else begin
      en_q <= en_nxt;
      if (reg_rd) rd_q <= rd_word;
    end
  end

  assign rd_data = rd_q;

  a_r7_enable_load: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && sel == SEL_ENABLE) |=> (en_q == $past(wfield)));
  a_r9_stray_write: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && sel == SEL_NONE) |=> $stable(en_q));
  a_r2_read_hold: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> $stable(rd_data));
endmodule

// File: rtl/intx_aggregator.sv
module intx_aggregator
  import intx_pkg::*;
#(
  parameter int NUM_PINS  = INTX_PINS,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int PIN_LSB   = 24,
  parameter int EN_ADDR   = 'h180,
  parameter int ST_ADDR   = 'h184,
  localparam int PIN_IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 asrt_vld,
  input  logic [PIN_IDX_W-1:0] asrt_pin,
  input  logic                 dsrt_vld,
  input  logic [PIN_IDX_W-1:0] dsrt_pin,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 irq_o
);
  logic [NUM_PINS-1:0] level;
  logic [NUM_PINS-1:0] status;
  logic [NUM_PINS-1:0] status_nxt;
  logic [NUM_PINS-1:0] en_q, en_nxt, w1c;
  logic                irq_q;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    intx_pin_cell #(.PIN_IDX_W(PIN_IDX_W), .PIN_ID(p)) u_cell (
      .clk          (clk),
      .rst          (rst),
      .asrt_vld     (asrt_vld),
      .asrt_pin     (asrt_pin),
      .dsrt_vld     (dsrt_vld),
      .dsrt_pin     (dsrt_pin),
      .clr          (w1c[p]),
      .level_o      (level[p]),
      .status_o     (status[p]),
      .status_nxt_o (status_nxt[p])
    );
  end

  intx_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PINS(NUM_PINS),
    .PIN_LSB(PIN_LSB), .EN_ADDR(EN_ADDR), .ST_ADDR(ST_ADDR)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .status_q  (status),
    .en_q      (en_q),
    .en_nxt    (en_nxt),
    .w1c       (w1c),
    .rd_data   (rd_data)
  );

  // Built from next-state values so the line moves on the same edge as the bits.
  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(status_nxt & en_nxt);
  end

  assign irq_o = irq_q;

  a_r8_irq_tracks: assert property (@(posedge clk) disable iff (rst)
    irq_o == |(status & en_q));
  a_r4_level_implies_status: assert property (@(posedge clk) disable iff (rst)
    (level & ~status) == '0);
endmodule

// File: tb/tb_intx_aggregator.sv
module tb_intx_aggregator;
  localparam logic [11:0] A_EN = 12'h180;
  localparam logic [11:0] A_ST = 12'h184;
  localparam logic [31:0] ALL4 = 32'h0F00_0000;

  logic        clk = 1'b0;
  logic        rst;
  logic        asrt_vld = 1'b0, dsrt_vld = 1'b0;
  logic [1:0]  asrt_pin = '0, dsrt_pin = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rd_data;
  logic        irq_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  intx_aggregator dut (
    .clk(clk), .rst(rst),
    .asrt_vld(asrt_vld), .asrt_pin(asrt_pin),
    .dsrt_vld(dsrt_vld), .dsrt_pin(dsrt_pin),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .rd_data(rd_data), .irq_o(irq_o)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic ev_assert(input int p);
    asrt_vld = 1'b1; asrt_pin = 2'(p); step(); asrt_vld = 1'b0; asrt_pin = '0;
  endtask

  task automatic ev_deassert(input int p);
    dsrt_vld = 1'b1; dsrt_pin = 2'(p); step(); dsrt_vld = 1'b0; dsrt_pin = '0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; step();
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a; step(); reg_rd = 1'b0; reg_addr = '0;
    d = rd_data;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1", "rd_data after reset", rd_data, 32'h0);
    check("R1", "irq after reset", {31'b0, irq_o}, 32'h0);
    rd(A_EN, v); check("R1", "unmask reg", v, 32'h0);
    rd(A_ST, v); check("R1", "status reg", v, 32'h0);
  endtask

  task automatic t_assert_basic();
    logic [31:0] v;
    wr(A_EN, ALL4);
    check("R8", "irq idle with all unmasked", {31'b0, irq_o}, 32'h0);
    ev_assert(2);
    check("R8", "irq right after assert edge", {31'b0, irq_o}, 32'h1);
    rd(A_ST, v); check("R3", "status after assert pin2 (bit26)", v, 32'h0400_0000);
    ev_assert(2);
    rd(A_ST, v); check("R3", "status after repeated assert", v, 32'h0400_0000);
    rd(A_EN, v); check("R2", "unmask readback", v, ALL4);
    reg_rd = 1'b0; step();
    check("R2", "rd_data holds without strobe", rd_data, ALL4);
  endtask

  task automatic t_clear_held();
    logic [31:0] v;
    wr(A_ST, 32'h0400_0000);
    rd(A_ST, v); check("R4", "clear on held level ignored", v, 32'h0400_0000);
    check("R4", "irq still high", {31'b0, irq_o}, 32'h1);
  endtask

  task automatic t_deassert_sticky();
    logic [31:0] v;
    ev_deassert(2);
    rd(A_ST, v); check("R5", "status sticky after deassert", v, 32'h0400_0000);
    wr(A_ST, 32'h0);
    rd(A_ST, v); check("R5", "write 0 leaves status", v, 32'h0400_0000);
    wr(A_ST, 32'h0400_0000);
    check("R8", "irq drops with clear", {31'b0, irq_o}, 32'h0);
    rd(A_ST, v); check("R5", "status cleared after deassert", v, 32'h0);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    ev_assert(1);
    wr(A_EN, 32'h0);
    check("R8", "masked pin hides irq", {31'b0, irq_o}, 32'h0);
    rd(A_ST, v); check("R7", "unmask write keeps status", v, 32'h0200_0000);
    rd(A_EN, v);
    wr(A_EN, v | 32'h0200_0000);
    check("R8", "unmask raises irq", {31'b0, irq_o}, 32'h1);
    rd(A_EN, v); check("R7", "unmask after RMW", v, 32'h0200_0000);
    dsrt_vld = 1'b1; dsrt_pin = 2'd1;
    reg_wr = 1'b1; reg_addr = A_ST; reg_wdata = 32'h0200_0000;
    step();
    dsrt_vld = 1'b0; dsrt_pin = '0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    check("R6", "irq after same-cycle deassert+clear", {31'b0, irq_o}, 32'h0);
    rd(A_ST, v); check("R6", "status after same-cycle deassert+clear", v, 32'h0);
  endtask

  task automatic t_outside();
    logic [31:0] v;
    wr(A_EN, 32'hFFFF_FFFF);
    rd(A_EN, v); check("R9", "unmask outside bits", v, ALL4);
    ev_assert(0);
    ev_deassert(0);
    wr(12'h188, 32'hFFFF_FFFF);
    rd(A_EN, v); check("R9", "stray write keeps unmask", v, ALL4);
    wr(A_ST, 32'hF0FF_FFFF);
    rd(A_ST, v); check("R9", "outside clear bits ignored", v, 32'h0100_0000);
    wr(A_ST, 32'h0100_0000);
    rd(A_ST, v); check("R9", "in-field clear works", v, 32'h0);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    asrt_vld = 1'b1; asrt_pin = 2'd3; dsrt_vld = 1'b1; dsrt_pin = 2'd3; step();
    asrt_vld = 1'b0; dsrt_vld = 1'b0; asrt_pin = '0; dsrt_pin = '0;
    rd(A_ST, v); check("R10", "same-pin assert+deassert", v, 32'h0);
    check("R10", "irq stays low", {31'b0, irq_o}, 32'h0);
    asrt_vld = 1'b1; asrt_pin = 2'd0; dsrt_vld = 1'b1; dsrt_pin = 2'd3; step();
    asrt_vld = 1'b0; dsrt_vld = 1'b0; asrt_pin = '0; dsrt_pin = '0;
    rd(A_ST, v); check("R10", "different pins both apply", v, 32'h0100_0000);
    ev_deassert(0);
    wr(A_ST, ALL4);
  endtask

  task automatic t_all_pins();
    logic [31:0] v;
    for (int p = 0; p < 4; p++) ev_assert(p);
    rd(A_ST, v); check("R3", "all four pins set", v, ALL4);
    for (int p = 0; p < 4; p++) ev_deassert(p);
    for (int p = 0; p < 4; p++) begin
      check("R8", $sformatf("irq before clearing pin %0d", p), {31'b0, irq_o}, 32'h1);
      wr(A_ST, 32'h1 << (24 + p));
    end
    check("R8", "irq after last clear", {31'b0, irq_o}, 32'h0);
    rd(A_ST, v); check("R5", "all cleared ascending", v, 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_assert_basic();
    t_clear_held();
    t_deassert_sticky();
    t_mask();
    t_outside();
    t_collide();
    t_all_pins();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule